// File: doc/BRIEF.md
# NAND Flash Command Sequence Decoder

This block is the device-side command interpreter of a small-page NAND flash. It watches the 8-bit I/O bus, the write strobe, the command-latch signal and chip enable. It takes a command byte when the write strobe rises while command-latch is high and the chip is selected. It classifies the byte and moves through the single-step read commands and the multi-step program, copy-back and erase sequences. When a sequence completes, it emits a one-cycle start pulse that carries an operation code.

The address phases are collected by a neighbouring block, which reports completion on a one-cycle `addr_done` input. A `busy` input from the array engines limits the accepted commands to status read and reset. The live write-protect level is examined when a program or erase sequence is confirmed. The block also drives an output-enable indication, which is low whenever the chip is deselected or a program, copy-back or erase sequence is pending. It reports a one-cycle-delayed copy of the write-protect level as a status bit.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A command byte is taken only at the first clock edge that samples `we_n` high after an edge that sampled it low, with `cle` high and `ce_n` low at that edge. With `cle` low, a write strobe has no effect.
- R2: The read codes set these operations: 00h gives operation 1, 01h gives 2, 50h gives 3, 90h gives 4 and 70h gives 5. The codes 00h, 01h and 50h also set `read_ptr` to 0, 1 and 2 respectively.
- R3: `op_valid` is high for exactly one cycle, in the cycle after the edge that takes the command, with `op_code` valid alongside. The operation encoding is: 1 read A, 2 read B, 3 read C, 4 read ID, 5 read status, 6 reset, 7 page program, 8 copy-back, 9 block erase.
- R4: The sequence 80h, then `addr_done`, then 10h produces operation 7. 80h and `addr_done` alone produce no pulse.
- R5: The sequence 60h, then `addr_done`, then D0h produces operation 9.
- R6: The sequence 00h, then `addr_done`, then 8Ah, then `addr_done`, then 10h produces operation 8. The 00h step still produces its own read-A pulse.
- R7: While `busy` is high, only 70h and FFh are accepted. Every other code, including a confirm, is dropped and leaves any pending sequence in place.
- R8: An undefined code, or a defined code out of sequence, produces no pulse and leaves the state unchanged. A read or start code sent while a program or erase sequence is pending counts as out of sequence. Read status (70h) is accepted at any point without disturbing a pending sequence.
- R9: If `wp_n` is low at the confirm of a program, copy-back or erase, no pulse is produced and the decoder returns to idle. Only the level at the confirm matters; the level during earlier steps does not.
- R10: With `ce_n` high, all bus cycles are ignored and `oe_en` is low. With `ce_n` low, `oe_en` is high exactly when no program, copy-back or erase sequence is pending.
- R11: FFh aborts any pending sequence, produces operation 6 and sets `read_ptr` to 0.
- R12: `wp_status` equals the level of `wp_n` one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command-latch enable |
| we_n | input | 1 | Write strobe, active low; captured on its rise |
| io | input | BUS_W | I/O bus; bits 7:0 carry the code |
| addr_done | input | 1 | One-cycle pulse marking an address phase complete |
| busy | input | 1 | Array engine busy |
| wp_n | input | 1 | Write protect, active low, not latched |
| op_valid | output | 1 | One-cycle operation start pulse |
| op_code | output | 4 | Operation code, valid with op_valid |
| read_ptr | output | 2 | Read area pointer: 0 A, 1 B, 2 C |
| oe_en | output | 1 | Output-enable indication |
| wp_status | output | 1 | Registered write-protect level |

## Verification
On every cycle, the embedded properties check the following. The start pulse lasts one cycle. A pulse taken while busy can only be status read or reset. A program, copy-back or erase pulse requires write-protect high at its confirm and the matching confirm state just before it. Reset always lands in idle with pointer A. A deselected chip never shows output enable and never launches an operation.

Only the directed scenarios can show the rest. These are that the correct code sequences produce the correct operations, and that ignored codes leave a pending sequence intact, which shows when the later confirm still works. They also cover that a refused confirm really drops the sequence, that write-protect is sampled live rather than held, and that strobes with `cle` low or `ce_n` high change nothing.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  localparam int CODE_W = 8;
  localparam int OP_W   = 4;
  localparam int PTR_W  = 2;

  localparam logic [CODE_W-1:0] CODE_READ_A   = 8'h00;
  localparam logic [CODE_W-1:0] CODE_READ_B   = 8'h01;
  localparam logic [CODE_W-1:0] CODE_READ_C   = 8'h50;
  localparam logic [CODE_W-1:0] CODE_READ_ID  = 8'h90;
  localparam logic [CODE_W-1:0] CODE_STATUS   = 8'h70;
  localparam logic [CODE_W-1:0] CODE_RESET    = 8'hFF;
  localparam logic [CODE_W-1:0] CODE_PROG     = 8'h80;
  localparam logic [CODE_W-1:0] CODE_ERASE    = 8'h60;
  localparam logic [CODE_W-1:0] CODE_CB_MID   = 8'h8A;
  localparam logic [CODE_W-1:0] CODE_PG_CONF  = 8'h10;
  localparam logic [CODE_W-1:0] CODE_ER_CONF  = 8'hD0;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 4'd0,
    OP_RD_A    = 4'd1,
    OP_RD_B    = 4'd2,
    OP_RD_C    = 4'd3,
    OP_RD_ID   = 4'd4,
    OP_RD_STAT = 4'd5,
    OP_RESET   = 4'd6,
    OP_PROG    = 4'd7,
    OP_COPY    = 4'd8,
    OP_ERASE   = 4'd9
  } op_e;

  typedef enum logic [3:0] {
    K_NONE,
    K_RD_A,
    K_RD_B,
    K_RD_C,
    K_RD_ID,
    K_STAT,
    K_RESET,
    K_PROG,
    K_ERASE,
    K_CB_MID,
    K_PG_CONF,
    K_ER_CONF
  } kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A0_ADDR,
    ST_A0_RDY,
    ST_PG_ADDR,
    ST_PG_DATA,
    ST_ER_ADDR,
    ST_ER_CONF,
    ST_CB_ADDR,
    ST_CB_CONF
  } st_e;

  typedef enum logic [PTR_W-1:0] {
    PTR_A = 2'd0,
    PTR_B = 2'd1,
    PTR_C = 2'd2
  } ptr_e;

endpackage

// File: rtl/nand_strobe_capture.sv
module nand_strobe_capture #(
  parameter int BUS_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ce_n,
  input  logic                                cle,
  input  logic                                we_n,
  input  logic [BUS_W-1:0]                    io,
  input  logic                                addr_done,
  output logic                                cmd_stb,
  output logic [nand_cmd_pkg::CODE_W-1:0]     cmd_byte,
  output logic                                addr_adv
);
  import nand_cmd_pkg::*;

  logic we_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
    end else begin
      we_q <= we_n;
    end
  end

  always_comb begin
    rise     = we_n & ~we_q;
    cmd_stb  = rise & cle & ~ce_n;
    cmd_byte = io[CODE_W-1:0];
    addr_adv = addr_done & ~ce_n;
  end

  // R1: a capture is never reported for a deselected chip or a data cycle
  assert_stb_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (cle && !ce_n && we_n));

  // R1: two captures cannot land on consecutive edges
  assert_stb_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

endmodule

// File: rtl/nand_code_classify.sv
module nand_code_classify (
  input  logic [nand_cmd_pkg::CODE_W-1:0] code,
  output nand_cmd_pkg::kind_e             kind
);
  import nand_cmd_pkg::*;

  always_comb begin
    case (code)
      CODE_READ_A:  kind = K_RD_A;
      CODE_READ_B:  kind = K_RD_B;
      CODE_READ_C:  kind = K_RD_C;
      CODE_READ_ID: kind = K_RD_ID;
      CODE_STATUS:  kind = K_STAT;
      CODE_RESET:   kind = K_RESET;
      CODE_PROG:    kind = K_PROG;
      CODE_ERASE:   kind = K_ERASE;
      CODE_CB_MID:  kind = K_CB_MID;
      CODE_PG_CONF: kind = K_PG_CONF;
      CODE_ER_CONF: kind = K_ER_CONF;
      default:      kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_stb,
  input  nand_cmd_pkg::kind_e  kind,
  input  logic                 addr_adv,
  input  logic                 busy,
  input  logic                 wp_n,
  output logic                 op_valid,
  output nand_cmd_pkg::op_e    op_code,
  output nand_cmd_pkg::ptr_e   read_ptr,
  output logic                 read_mode
);
  import nand_cmd_pkg::*;

  st_e  st_q,  st_d;
  ptr_e ptr_q, ptr_d;
  op_e  op_q,  op_d;
  logic opv_q, opv_d;
  logic rd_mode;

  always_comb begin
    rd_mode = (st_q == ST_IDLE) || (st_q == ST_A0_ADDR) || (st_q == ST_A0_RDY);
  end

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    op_d  = op_q;
    opv_d = 1'b0;
    if (cmd_stb) begin
      if (busy) begin
        if (kind == K_STAT) begin
          opv_d = 1'b1;
          op_d  = OP_RD_STAT;
        end else if (kind == K_RESET) begin
          opv_d = 1'b1;
          op_d  = OP_RESET;
          st_d  = ST_IDLE;
          ptr_d = PTR_A;
        end
      end else begin
        case (kind)
          K_RESET: begin
            opv_d = 1'b1;
            op_d  = OP_RESET;
            st_d  = ST_IDLE;
            ptr_d = PTR_A;
          end
          K_STAT: begin
            opv_d = 1'b1;
            op_d  = OP_RD_STAT;
          end
          K_RD_A: if (rd_mode) begin
            opv_d = 1'b1;
            op_d  = OP_RD_A;
            ptr_d = PTR_A;
            st_d  = ST_A0_ADDR;
          end
          K_RD_B: if (rd_mode) begin
            opv_d = 1'b1;
            op_d  = OP_RD_B;
            ptr_d = PTR_B;
            st_d  = ST_IDLE;
          end
          K_RD_C: if (rd_mode) begin
            opv_d = 1'b1;
            op_d  = OP_RD_C;
            ptr_d = PTR_C;
            st_d  = ST_IDLE;
          end
          K_RD_ID: if (rd_mode) begin
            opv_d = 1'b1;
            op_d  = OP_RD_ID;
            st_d  = ST_IDLE;
          end
          K_PROG: if (rd_mode) begin
            st_d = ST_PG_ADDR;
          end
          K_ERASE: if (rd_mode) begin
            st_d = ST_ER_ADDR;
          end
          K_CB_MID: if (st_q == ST_A0_RDY) begin
            st_d = ST_CB_ADDR;
          end
          K_PG_CONF: if (st_q == ST_PG_DATA || st_q == ST_CB_CONF) begin
            st_d = ST_IDLE;
            if (wp_n) begin
              opv_d = 1'b1;
              op_d  = (st_q == ST_PG_DATA) ? OP_PROG : OP_COPY;
            end
          end
          K_ER_CONF: if (st_q == ST_ER_CONF) begin
            st_d = ST_IDLE;
            if (wp_n) begin
              opv_d = 1'b1;
              op_d  = OP_ERASE;
            end
          end
          default: ;
        endcase
      end
    end else if (addr_adv) begin
      case (st_q)
        ST_A0_ADDR: st_d = ST_A0_RDY;
        ST_PG_ADDR: st_d = ST_PG_DATA;
        ST_ER_ADDR: st_d = ST_ER_CONF;
        ST_CB_ADDR: st_d = ST_CB_CONF;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= PTR_A;
      op_q  <= OP_NONE;
      opv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      op_q  <= op_d;
      opv_q <= opv_d;
    end
  end

  always_comb begin
    op_valid  = opv_q;
    op_code   = op_q;
    read_ptr  = ptr_q;
    read_mode = rd_mode;
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  assert_busy_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(busy)) |-> (op_q == OP_RD_STAT || op_q == OP_RESET));

  assert_wp_confirm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_q == OP_PROG || op_q == OP_COPY || op_q == OP_ERASE)) |-> $past(wp_n));

  assert_reset_home_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_q == OP_RESET) |-> (st_q == ST_IDLE && ptr_q == PTR_A));

  assert_prog_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_q == OP_PROG) |-> ($past(st_q) == ST_PG_DATA));

  assert_erase_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_q == OP_ERASE) |-> ($past(st_q) == ST_ER_CONF));

  assert_copy_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_q == OP_COPY) |-> ($past(st_q) == ST_CB_CONF));

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             we_n,
  input  logic [BUS_W-1:0] io,
  input  logic             addr_done,
  input  logic             busy,
  input  logic             wp_n,
  output logic             op_valid,
  output logic [3:0]       op_code,
  output logic [1:0]       read_ptr,
  output logic             oe_en,
  output logic             wp_status
);
  import nand_cmd_pkg::*;

  logic              cmd_stb;
  logic [CODE_W-1:0] cmd_byte;
  logic              addr_adv;
  kind_e             kind;
  op_e               op_w;
  ptr_e              ptr_w;
  logic              read_mode;
  logic              wp_q;

  nand_strobe_capture #(.BUS_W(BUS_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .cle       (cle),
    .we_n      (we_n),
    .io        (io),
    .addr_done (addr_done),
    .cmd_stb   (cmd_stb),
    .cmd_byte  (cmd_byte),
    .addr_adv  (addr_adv)
  );

  nand_code_classify u_cls (
    .code (cmd_byte),
    .kind (kind)
  );

  nand_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stb   (cmd_stb),
    .kind      (kind),
    .addr_adv  (addr_adv),
    .busy      (busy),
    .wp_n      (wp_n),
    .op_valid  (op_valid),
    .op_code   (op_w),
    .read_ptr  (ptr_w),
    .read_mode (read_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= 1'b0;
    end else begin
      wp_q <= wp_n;
    end
  end

  always_comb begin
    op_code   = op_w;
    read_ptr  = ptr_w;
    oe_en     = read_mode & ~ce_n;
    wp_status = wp_q;
  end

  assert_deselect_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !oe_en);

  assert_deselect_no_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !$past(ce_n));

endmodule

// File: tb/tb_nand_cmd_decoder.sv
module tb_nand_cmd_decoder;

  logic       clk;
  logic       rst_n;
  logic       ce_n;
  logic       cle;
  logic       we_n;
  logic [7:0] io;
  logic       addr_done;
  logic       busy;
  logic       wp_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [1:0] read_ptr;
  logic       oe_en;
  logic       wp_status;

  int checks;
  int errors;
  bit finished;

  nand_cmd_decoder #(.BUS_W(8)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .cle       (cle),
    .we_n      (we_n),
    .io        (io),
    .addr_done (addr_done),
    .busy      (busy),
    .wp_n      (wp_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .read_ptr  (read_ptr),
    .oe_en     (oe_en),
    .wp_status (wp_status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Write one command byte; returns in the cycle where a start pulse would show
  task automatic issue(input logic [7:0] b);
    @(negedge clk);
    cle  = 1'b1;
    io   = b;
    we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cle  = 1'b0;
  endtask

  task automatic addr_phase();
    @(negedge clk);
    addr_done = 1'b1;
    @(negedge clk);
    addr_done = 1'b0;
  endtask

  task automatic expect_op(input string tag, input logic [3:0] code);
    chk({tag, " op_valid"}, {7'd0, op_valid}, 8'd1);
    chk({tag, " op_code"}, {4'd0, op_code}, {4'd0, code});
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " no pulse"}, {7'd0, op_valid}, 8'd0);
  endtask

  task automatic t_reset_state();
    chk("R3 reset op_valid", {7'd0, op_valid}, 8'd0);
    chk("R3 reset op_code", {4'd0, op_code}, 8'd0);
    chk("R11 reset read_ptr", {6'd0, read_ptr}, 8'd0);
    chk("R10 reset oe_en", {7'd0, oe_en}, 8'd1);
  endtask

  task automatic t_reads();
    issue(8'h01); expect_op("R2 read B", 4'd2);
    chk("R2 ptr B", {6'd0, read_ptr}, 8'd1);
    @(negedge clk);
    chk("R3 pulse width", {7'd0, op_valid}, 8'd0);
    issue(8'h50); expect_op("R2 read C", 4'd3);
    chk("R2 ptr C", {6'd0, read_ptr}, 8'd2);
    issue(8'h90); expect_op("R2 read ID", 4'd4);
    chk("R2 ptr kept", {6'd0, read_ptr}, 8'd2);
    issue(8'h70); expect_op("R2 status", 4'd5);
    issue(8'h00); expect_op("R2 read A", 4'd1);
    chk("R2 ptr A", {6'd0, read_ptr}, 8'd0);
  endtask

  task automatic t_capture();
    @(negedge clk);
    cle = 1'b0; io = 8'h90; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    expect_none("R1 cle low");
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    chk("R10 oe_en deselected", {7'd0, oe_en}, 8'd0);
    issue(8'h90);
    expect_none("R10 deselected strobe");
    issue(8'h80);
    addr_phase();
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk);
    chk("R10 oe_en selected idle", {7'd0, oe_en}, 8'd1);
    issue(8'h10);
    expect_none("R10 no program started while deselected");
  endtask

  task automatic t_program();
    issue(8'h80); expect_none("R4 start");
    chk("R10 oe_en pending", {7'd0, oe_en}, 8'd0);
    addr_phase(); expect_none("R4 addr");
    issue(8'h10); expect_op("R4 program", 4'd7);
    chk("R10 oe_en after", {7'd0, oe_en}, 8'd1);
  endtask

  task automatic t_erase();
    issue(8'h60); expect_none("R5 start");
    addr_phase();
    issue(8'h10); expect_none("R8 wrong confirm for erase");
    issue(8'hD0); expect_op("R5 erase", 4'd9);
  endtask

  task automatic t_copyback();
    issue(8'h00); expect_op("R6 first step read A", 4'd1);
    addr_phase();
    issue(8'h8A); expect_none("R6 middle step");
    chk("R6 oe_en pending", {7'd0, oe_en}, 8'd0);
    addr_phase();
    issue(8'h10); expect_op("R6 copy-back", 4'd8);
  endtask

  task automatic t_busy();
    @(negedge clk); busy = 1'b1;
    issue(8'h90); expect_none("R7 read ID busy");
    issue(8'h80); expect_none("R7 program start busy");
    chk("R7 state kept", {7'd0, oe_en}, 8'd1);
    issue(8'h70); expect_op("R7 status busy", 4'd5);
    issue(8'h50); expect_none("R7 read C busy");
    issue(8'hFF); expect_op("R7 reset busy", 4'd6);
    @(negedge clk); busy = 1'b0;
    issue(8'h80); addr_phase();
    @(negedge clk); busy = 1'b1;
    issue(8'h10); expect_none("R7 confirm dropped busy");
    @(negedge clk); busy = 1'b0;
    issue(8'h10); expect_op("R7 pending kept", 4'd7);
  endtask

  task automatic t_undefined();
    issue(8'h33); expect_none("R8 undefined");
    chk("R8 undefined oe", {7'd0, oe_en}, 8'd1);
    issue(8'h10); expect_none("R8 confirm in idle");
    issue(8'h8A); expect_none("R8 copy mid in idle");
    issue(8'h80); addr_phase();
    issue(8'hD0); expect_none("R8 erase confirm in program");
    issue(8'h90); expect_none("R8 read ID in program");
    issue(8'h5A); expect_none("R8 undefined in program");
    chk("R8 still pending", {7'd0, oe_en}, 8'd0);
    issue(8'h70); expect_op("R8 status in program", 4'd5);
    chk("R8 status keeps pending", {7'd0, oe_en}, 8'd0);
    issue(8'h10); expect_op("R8 program after ignored", 4'd7);
  endtask

  task automatic t_wp();
    issue(8'h80); addr_phase();
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk);
    chk("R12 wp_status low", {7'd0, wp_status}, 8'd0);
    issue(8'h10); expect_none("R9 program refused");
    chk("R9 back to idle", {7'd0, oe_en}, 8'd1);
    @(negedge clk); wp_n = 1'b1;
    issue(8'h10); expect_none("R9 no retry after refuse");
    issue(8'h60); addr_phase();
    @(negedge clk); wp_n = 1'b0;
    issue(8'hD0); expect_none("R9 erase refused");
    issue(8'h80);
    addr_phase();
    @(negedge clk); wp_n = 1'b1;
    @(negedge clk);
    chk("R12 wp_status high", {7'd0, wp_status}, 8'd1);
    issue(8'h10); expect_op("R9 live sample", 4'd7);
  endtask

  task automatic t_reset_abort();
    issue(8'h01);
    issue(8'h60); addr_phase();
    issue(8'hFF); expect_op("R11 reset", 4'd6);
    chk("R11 ptr A", {6'd0, read_ptr}, 8'd0);
    chk("R11 idle", {7'd0, oe_en}, 8'd1);
    issue(8'hD0); expect_none("R11 erase aborted");
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; ce_n = 1'b0; cle = 1'b0; we_n = 1'b1; io = 8'h00;
    addr_done = 1'b0; busy = 1'b0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reads();
    t_capture();
    t_program();
    t_erase();
    t_copyback();
    t_busy();
    t_undefined();
    t_wp();
    t_reset_abort();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200us;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule